// File: doc/BRIEF.md
# Infrared receive run-length sampler with split sample ring

The block watches a demodulated infrared input. It samples the input once per programmable sample period and measures how many periods each pulse or space lasts. Every finished run is packed into one byte and stored in a circular sample store. A host follows the write pointer, reads entries by logical index and clears a sticky receive interrupt.

The store is built from three physical regions. A fixed 8-entry main region comes first, followed by two extra regions whose lengths are configurable up to the `MAX1` and `MAX2` parameters. The block maps each logical ring index onto one of these regions, for its own writes and for the host read port. If the configured lengths give an unusable ring, the extra regions are switched off and the ring becomes the 8-entry main region, treated as two halves of four entries. A flag then shows which half is being filled.

Configuration is captured when reception is enabled. The host reads with a purely combinational port: it drives an index and gets the byte back in the same cycle.

Top module: `irrx_sample_ring`

## Requirements
- R1: A stored byte has bit 7 set for a space (`ir_i` low) and clear for a pulse (`ir_i` high). Bits 6:0 hold the run length counted in sample periods, which is never zero.
- R2: The sample period is `period_i` units, each unit lasting `CLK_PER_US` clocks. Values 5 to 127 are used as given and values below 5 select 50. The first sample is taken one full period after enable. The first run is then counted from that sample, and a run is stored when the input level changes.
- R3: With `ovf_en_i` set, a run that reaches a 128th period stores a byte of length 127 and keeps counting the same run from 1. With `ovf_en_i` clear, the count sticks at 127 and one byte of length 127 is stored when the run ends.
- R4: In extended mode, logical indices 0 to 7 address the main region, the next `len1_i` indices address extra region 1 and the next `len2_i` indices address extra region 2. The ring length is `len1_i + len2_i + 8`, and `rd_valid_o` is high for every index below it.
- R5: Extended mode is used only when the ring length lies between 16 and 64 inclusive, `len1_i <= MAX1` and `len2_i <= MAX2`. Otherwise the ring length is 8. `ext_mode_o` shows the mode in use.
- R6: `wptr_o` advances by one for each stored byte and wraps to 0 when it reaches the ring length. The ring is empty when the host read index equals `wptr_o`.
- R7: In fallback mode, `half_o` is 1 while entries 4 to 7 are being written and 0 for entries 0 to 3. It is always 0 in extended mode.
- R8: A read index at or beyond the ring length gives `rd_valid_o` = 0 and `rd_data_o` = 0.
- R9: `irq_o` is set by every stored byte and stays set until a cycle with `irq_clr_i` high. If a byte is stored in that same cycle, the set takes priority.
- R10: The period, overflow enable and region lengths are captured on the rising edge of `rx_en_i`, which also resets `wptr_o` to 0. Changes to them while enabled have no effect. While `rx_en_i` is low, nothing is sampled and `wptr_o` holds.
- R11: After reset, `wptr_o`, `irq_o`, `ext_mode_o` and `half_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Reception enable; its rising edge captures the configuration |
| ir_i | input | 1 | Demodulated infrared level, high = pulse |
| period_i | input | 7 | Sample period in units |
| ovf_en_i | input | 1 | Enables storing saturated bytes in the middle of a run |
| len1_i | input | LEN_W | Length of extra region 1 |
| len2_i | input | LEN_W | Length of extra region 2 |
| irq_clr_i | input | 1 | Clears the receive interrupt |
| rd_idx_i | input | IDX_W | Logical index read by the host |
| wptr_o | output | IDX_W | Write pointer |
| half_o | output | 1 | Fallback half currently being written |
| ext_mode_o | output | 1 | Extended regions in use |
| irq_o | output | 1 | Sticky receive interrupt |
| rd_valid_o | output | 1 | Read index lies inside the ring |
| rd_data_o | output | 8 | Byte at the read index |

## Verification
The bench builds the block with `CLK_PER_US` = 2, so a 5-unit period is only 10 clocks. This makes runs of several hundred periods, saturated splits and wraps of a full 64-entry ring affordable. `MAX1` and `MAX2` keep their value of 32, so an extra region of 33 entries is rejected even though the total ring length would be legal. A default-period run at 100 clocks per sample checks the substitution for out-of-range periods.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam int unsigned MAIN_LEN   = 8;
  localparam int unsigned RUN_MAX    = 127;
  localparam int unsigned DEF_PERIOD = 50;
  localparam int unsigned MIN_PERIOD = 5;

  typedef struct packed {
    logic       space;
    logic [6:0] len;
  } smp_t;
endpackage

// File: rtl/irrx_tick_gen.sv
module irrx_tick_gen #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic [6:0] period_i,
  output logic       tick_o
);
  localparam int unsigned PRE_W = $clog2(CLK_PER_US + 1);

  logic [PRE_W-1:0] pre_q;
  logic [6:0]       unit_q;
  logic             unit_tick;

  assign unit_tick = run_i && (pre_q == PRE_W'(CLK_PER_US - 1));
  assign tick_o    = unit_tick && (unit_q == period_i - 7'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (clear_i) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (run_i) begin
      if (unit_tick) begin
        pre_q  <= '0;
        unit_q <= tick_o ? 7'd0 : unit_q + 7'd1;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/irrx_run_enc.sv
module irrx_run_enc
  import irrx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  input  logic ir_i,
  input  logic ovf_en_i,
  output logic smp_v_o,
  output smp_t smp_o
);
  logic       started_q;
  logic       lvl_q;
  logic [6:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      lvl_q     <= 1'b0;
      cnt_q     <= '0;
      smp_v_o   <= 1'b0;
      smp_o     <= '0;
    end else begin
      smp_v_o <= 1'b0;
      if (clear_i) begin
        started_q <= 1'b0;
        lvl_q     <= 1'b0;
        cnt_q     <= '0;
      end else if (tick_i) begin
        if (!started_q) begin
          started_q <= 1'b1;
          lvl_q     <= ir_i;
          cnt_q     <= 7'd1;
        end else if (ir_i != lvl_q) begin
          smp_v_o   <= 1'b1;
          smp_o     <= '{space: ~lvl_q, len: cnt_q};
          lvl_q     <= ir_i;
          cnt_q     <= 7'd1;
        end else if (cnt_q == 7'(RUN_MAX)) begin
          if (ovf_en_i) begin
            smp_v_o <= 1'b1;
            smp_o   <= '{space: ~lvl_q, len: cnt_q};
            cnt_q   <= 7'd1;
          end
        end else begin
          cnt_q <= cnt_q + 7'd1;
        end
      end
    end
  end
endmodule

// File: rtl/irrx_ring_map.sv
module irrx_ring_map
  import irrx_pkg::*;
#(
  parameter int unsigned MAX1   = 32,
  parameter int unsigned MAX2   = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned LEN_W  = 6,
  parameter int unsigned PHYS_W = 7
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ext_i,
  input  logic [LEN_W-1:0]  len1_i,
  input  logic [LEN_W-1:0]  len2_i,
  output logic              valid_o,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int unsigned SUM_W = (IDX_W > LEN_W ? IDX_W : LEN_W) + 2;
  localparam int unsigned R2_BASE = MAIN_LEN + MAX1;

  logic [SUM_W-1:0] idx_w, end1, end2;

  always_comb begin
    idx_w   = SUM_W'(idx_i);
    end1    = SUM_W'(MAIN_LEN) + SUM_W'(len1_i);
    end2    = end1 + SUM_W'(len2_i);
    valid_o = 1'b0;
    phys_o  = '0;
    if (idx_w < SUM_W'(MAIN_LEN)) begin
      valid_o = 1'b1;
      phys_o  = PHYS_W'(idx_w);
    end else if (ext_i && idx_w < end1) begin
      valid_o = 1'b1;
      phys_o  = PHYS_W'(idx_w);
    end else if (ext_i && idx_w < end2) begin
      valid_o = 1'b1;
      phys_o  = PHYS_W'(idx_w - end1 + SUM_W'(R2_BASE));
    end
  end
endmodule

// File: rtl/irrx_sample_ring.sv
module irrx_sample_ring
  import irrx_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned MAX1       = 32,
  parameter int unsigned MAX2       = 32,
  parameter int unsigned LEN_W      = 6,
  parameter int unsigned MIN_RING   = 16,
  parameter int unsigned MAX_RING   = 64,
  localparam int unsigned IDX_W     = $clog2(MAX_RING + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             ir_i,
  input  logic [6:0]       period_i,
  input  logic             ovf_en_i,
  input  logic [LEN_W-1:0] len1_i,
  input  logic [LEN_W-1:0] len2_i,
  input  logic             irq_clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] wptr_o,
  output logic             half_o,
  output logic             ext_mode_o,
  output logic             irq_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o
);
  localparam int unsigned DEPTH  = MAIN_LEN + MAX1 + MAX2;
  localparam int unsigned PHYS_W = $clog2(DEPTH);
  localparam int unsigned TOT_W  = LEN_W + 2;

  logic             en_q, start, run;
  logic [6:0]       per_q;
  logic             ovf_q, ext_q;
  logic [LEN_W-1:0] len1_q, len2_q;
  logic [IDX_W-1:0] ring_len_q, wptr_q;
  logic [TOT_W-1:0] total;
  logic             ext_ok, per_ok;

  assign start = rx_en_i && !en_q;
  assign run   = rx_en_i && en_q;

  assign total  = TOT_W'(MAIN_LEN) + TOT_W'(len1_i) + TOT_W'(len2_i);
  assign ext_ok = (total >= TOT_W'(MIN_RING)) && (total <= TOT_W'(MAX_RING)) &&
                  (TOT_W'(len1_i) <= TOT_W'(MAX1)) && (TOT_W'(len2_i) <= TOT_W'(MAX2));
  assign per_ok = period_i >= 7'(MIN_PERIOD);

  // configuration capture on enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      per_q      <= 7'(DEF_PERIOD);
      ovf_q      <= 1'b0;
      ext_q      <= 1'b0;
      len1_q     <= '0;
      len2_q     <= '0;
      ring_len_q <= IDX_W'(MAIN_LEN);
    end else begin
      en_q <= rx_en_i;
      if (start) begin
        per_q      <= per_ok ? period_i : 7'(DEF_PERIOD);
        ovf_q      <= ovf_en_i;
        ext_q      <= ext_ok;
        len1_q     <= ext_ok ? len1_i : '0;
        len2_q     <= ext_ok ? len2_i : '0;
        ring_len_q <= ext_ok ? IDX_W'(total) : IDX_W'(MAIN_LEN);
      end
    end
  end

  logic tick;
  irrx_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clear_i  (start),
    .period_i (per_q),
    .tick_o   (tick)
  );

  logic smp_v;
  smp_t smp;
  irrx_run_enc u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start),
    .tick_i   (tick),
    .ir_i     (ir_i),
    .ovf_en_i (ovf_q),
    .smp_v_o  (smp_v),
    .smp_o    (smp)
  );

  logic              wr_en;
  logic [7:0]        wr_data;
  logic              wr_valid;
  logic [PHYS_W-1:0] wr_phys;

  assign wr_en   = smp_v && run;
  assign wr_data = smp;

  irrx_ring_map #(
    .MAX1(MAX1), .MAX2(MAX2), .IDX_W(IDX_W), .LEN_W(LEN_W), .PHYS_W(PHYS_W)
  ) u_wmap (
    .idx_i   (wptr_q),
    .ext_i   (ext_q),
    .len1_i  (len1_q),
    .len2_i  (len2_q),
    .valid_o (wr_valid),
    .phys_o  (wr_phys)
  );

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en && wr_valid) mem_q[wr_phys] <= wr_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (start)
        wptr_q <= '0;
      else if (wr_en)
        wptr_q <= (wptr_q == ring_len_q - IDX_W'(1)) ? '0 : wptr_q + IDX_W'(1);
      if (wr_en)
        irq_o <= 1'b1;
      else if (irq_clr_i)
        irq_o <= 1'b0;
    end
  end

  logic              rd_map_valid;
  logic [PHYS_W-1:0] rd_phys;

  irrx_ring_map #(
    .MAX1(MAX1), .MAX2(MAX2), .IDX_W(IDX_W), .LEN_W(LEN_W), .PHYS_W(PHYS_W)
  ) u_rmap (
    .idx_i   (rd_idx_i),
    .ext_i   (ext_q),
    .len1_i  (len1_q),
    .len2_i  (len2_q),
    .valid_o (rd_map_valid),
    .phys_o  (rd_phys)
  );

  assign rd_valid_o = rd_map_valid;
  assign rd_data_o  = rd_map_valid ? mem_q[rd_phys] : 8'h00;
  assign wptr_o     = wptr_q;
  assign ext_mode_o = ext_q;
  assign half_o     = !ext_q && wptr_q[2];
endmodule

// File: rtl/irrx_sample_ring_chk.sv
module irrx_sample_ring_chk #(
  parameter int unsigned IDX_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             irq_clr_i,
  input logic [IDX_W-1:0] wptr_o,
  input logic             irq_o,
  input logic             ext_mode_o,
  input logic             half_o,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             rd_valid_o,
  input logic [IDX_W-1:0] ring_len_q,
  input logic             wr_en,
  input logic [7:0]       wr_data
);
  p_len_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_data[6:0] != 7'd0);

  p_fallback_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_o |-> wptr_o < IDX_W'(8));

  p_wptr_in_ring_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_o < ring_len_q);

  p_wptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr_o != $past(wptr_o)) |-> (wptr_o == $past(wptr_o) + IDX_W'(1) || wptr_o == '0));

  p_half_only_fallback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> !ext_mode_o);

  p_rd_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_idx_i < ring_len_q);

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_en));

  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !wr_en) |=> !irq_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> $stable(wptr_o));
endmodule

bind irrx_sample_ring irrx_sample_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .irq_clr_i  (irq_clr_i),
  .wptr_o     (wptr_o),
  .irq_o      (irq_o),
  .ext_mode_o (ext_mode_o),
  .half_o     (half_o),
  .rd_idx_i   (rd_idx_i),
  .rd_valid_o (rd_valid_o),
  .ring_len_q (ring_len_q),
  .wr_en      (wr_en),
  .wr_data    (wr_data)
);

// File: tb/irrx_sample_ring_test.sv
module irrx_sample_ring_test;
  localparam int unsigned CPU   = 2;
  localparam int unsigned LEN_W = 6;
  localparam int unsigned IDX_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rx_en_i = 1'b0;
  logic             ir_i = 1'b0;
  logic [6:0]       period_i = 7'd5;
  logic             ovf_en_i = 1'b0;
  logic [LEN_W-1:0] len1_i = '0;
  logic [LEN_W-1:0] len2_i = '0;
  logic             irq_clr_i = 1'b0;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic [IDX_W-1:0] wptr_o;
  logic             half_o, ext_mode_o, irq_o, rd_valid_o;
  logic [7:0]       rd_data_o;

  always #5 clk_i = ~clk_i;

  irrx_sample_ring #(.CLK_PER_US(CPU), .MAX1(32), .MAX2(32), .LEN_W(LEN_W)) uut (
    .clk_i, .rst_ni, .rx_en_i, .ir_i, .period_i, .ovf_en_i, .len1_i, .len2_i,
    .irq_clr_i, .rd_idx_i, .wptr_o, .half_o, .ext_mode_o, .irq_o, .rd_valid_o, .rd_data_o
  );

  int    tests = 0, fails = 0;
  byte   exp_q[$];
  int    rptr = 0, ring_len_exp = 8, per_clk = 10;
  bit    mon_on = 0, first = 1, ovf_exp = 0, prev_lvl = 0;
  int    prev_rem = 0;
  string req_tag = "R1";

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk_i);
    #2;
    if (mon_on && int'(wptr_o) != rptr) begin
      rd_idx_i = IDX_W'(rptr);
      #1;
      check(rd_valid_o, "R4", rd_valid_o, 1);
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected byte act=%0h exp=none", req_tag, rd_data_o);
      end else begin
        byte e;
        e = exp_q.pop_front();
        if (rd_data_o != 8'(e)) begin
          fails++;
          $display("FAIL %s byte idx %0d act=%0h exp=%0h", req_tag, rptr, rd_data_o, 8'(e));
        end
      end
      rptr = (rptr + 1 == ring_len_exp) ? 0 : rptr + 1;
    end
  end

  task automatic push(bit lvl, int len);
    exp_q.push_back(byte'({~lvl, 7'(len)}));
  endtask

  task automatic start_run(int per, bit ovf, int l1, int l2, int rl, bit lvl0);
    @(negedge clk_i);
    mon_on = 0;
    rx_en_i = 0;
    @(negedge clk_i);
    period_i = 7'(per); ovf_en_i = ovf; len1_i = LEN_W'(l1); len2_i = LEN_W'(l2);
    ir_i = lvl0;
    rx_en_i = 1;
    per_clk = CPU * ((per < 5) ? 50 : per);
    ovf_exp = ovf; ring_len_exp = rl; first = 1;
    exp_q.delete();
    @(negedge clk_i);
    rptr = 0;
    mon_on = 1;
  endtask

  // hold a level for n sample periods; model the bytes it produces
  task automatic hold(bit lvl, int n);
    int cnt, k;
    cnt = first ? n - 1 : n;
    if (!first) push(prev_lvl, prev_rem);
    if (ovf_exp) begin
      k = (cnt - 1) / 127;
      for (int i = 0; i < k; i++) push(lvl, 127);
      prev_rem = cnt - 127 * k;
    end else begin
      prev_rem = (cnt > 127) ? 127 : cnt;
    end
    prev_lvl = lvl;
    ir_i = lvl;
    repeat (n * per_clk - (first ? 1 : 0)) @(negedge clk_i);
    first = 0;
  endtask

  task automatic drain(string req);
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R11 reset state
    check(wptr_o == 0, "R11", wptr_o, 0);
    check(irq_o == 0, "R11", irq_o, 0);
    check(ext_mode_o == 0 && half_o == 0, "R11", {ext_mode_o, half_o}, 0);

    // fallback ring, R1 / R7
    req_tag = "R1";
    start_run(5, 1, 0, 0, 8, 1);
    for (int i = 0; i < 6; i++) hold(((i % 2) == 0), 2 + (i % 3));
    check(ext_mode_o == 0, "R5", ext_mode_o, 0);
    check(wptr_o == 5, "R6", wptr_o, 5);
    check(half_o == 1, "R7", half_o, 1);
    for (int i = 6; i < 12; i++) hold(((i % 2) == 0), 1 + (i % 4) + (i == 6 ? 0 : 0));
    drain("R1");
    check(wptr_o == 3, "R6", wptr_o, 3);
    check(half_o == 0, "R7", half_o, 0);
    check(irq_o == 1, "R9", irq_o, 1);
    rx_en_i = 0;
    @(negedge clk_i);
    irq_clr_i = 1;
    @(negedge clk_i);
    irq_clr_i = 0;
    check(irq_o == 0, "R9", irq_o, 1'b0);

    // extended ring 8+5+6 = 19, R4 / R10
    req_tag = "R4";
    start_run(5, 1, 5, 6, 19, 0);
    check(ext_mode_o == 1, "R5", ext_mode_o, 1);
    for (int i = 0; i < 22; i++) begin
      if (i == 4) len1_i = LEN_W'(20);  // ignored while enabled
      hold(((i % 2) == 1), 2 + (i % 4));
    end
    drain("R4");
    check(wptr_o == 2, "R10", wptr_o, 2);
    check(irq_o == 1, "R9", irq_o, 1);
    mon_on = 0;
    @(negedge clk_i); #2;
    rd_idx_i = 7'd18; #1;
    check(rd_valid_o == 1, "R4", rd_valid_o, 1);
    rd_idx_i = 7'd13; #1;
    check(rd_valid_o == 1, "R4", rd_valid_o, 1);
    rd_idx_i = 7'd19; #1;
    check(rd_valid_o == 0, "R8", rd_valid_o, 0);
    check(rd_data_o == 0, "R8", rd_data_o, 0);
    rd_idx_i = 7'd60; #1;
    check(rd_valid_o == 0, "R8", rd_valid_o, 0);
    // disabled: toggling input has no effect
    rx_en_i = 0;
    for (int i = 0; i < 20; i++) begin
      ir_i = ~ir_i;
      repeat (15) @(negedge clk_i);
    end
    check(wptr_o == 2, "R10", wptr_o, 2);

    // boundary: 8+28+28 = 64 is accepted
    req_tag = "R5";
    start_run(5, 1, 28, 28, 64, 1);
    check(wptr_o == 0, "R10", wptr_o, 0);
    check(ext_mode_o == 1, "R5", ext_mode_o, 1);
    hold(1, 2);
    for (int i = 0; i < 70; i++) hold(((i % 2) == 1), 1);
    drain("R5");
    check(wptr_o == 6, "R6", wptr_o, 6);
    start_run(5, 1, 30, 30, 8, 0);
    check(ext_mode_o == 0, "R5", ext_mode_o, 0);
    start_run(5, 1, 3, 4, 8, 0);
    check(ext_mode_o == 0, "R5", ext_mode_o, 0);
    start_run(5, 1, 33, 0, 8, 0);
    check(ext_mode_o == 0, "R5", ext_mode_o, 0);

    // saturation
    req_tag = "R3";
    start_run(5, 1, 0, 0, 8, 1);
    hold(1, 2); hold(0, 300); hold(1, 3); hold(0, 1);
    drain("R3");
    check(wptr_o == 5, "R3", wptr_o, 5);
    start_run(5, 0, 0, 0, 8, 1);
    hold(1, 2); hold(0, 200); hold(1, 2); hold(0, 1);
    drain("R3");
    check(wptr_o == 3, "R3", wptr_o, 3);

    // period selection
    req_tag = "R2";
    start_run(3, 0, 0, 0, 8, 1);
    hold(1, 3); hold(0, 2); hold(1, 2); hold(0, 1);
    drain("R2");
    start_run(9, 0, 0, 0, 8, 0);
    hold(0, 2); hold(1, 3); hold(0, 4); hold(1, 1);
    drain("R2");
    check(wptr_o == 3, "R2", wptr_o, 3);

    rx_en_i = 0;
    mon_on = 0;
    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule